// File: doc/BRIEF.md
# Hybrid Network Traffic Volume Predictor

This block sits next to a node's network interface. It forecasts how much payload the node will send to each destination during the next sampling period. It adds up the payload bytes of every outgoing flit per destination. On each period tick it reduces every byte total to a 2-bit volume level. It then walks the destinations one per cycle. For each destination it scores the old forecasts against the level just measured, updates its state and issues new forecasts.

Two forecasts exist for each destination. The first simply repeats the level just measured. The second looks up a small table, shared by all destinations and fully associative. That table is keyed by the destination and its last four levels, and it holds the level that followed that history last time. A 2-bit saturating chooser per destination picks which forecast is presented. Replacement in the shared table is least-recently-written.

A consumer reads the forecast for any destination through a combinational query port. Running hit and miss totals for both forecasts are available for accuracy studies.

Top module: `nvp_traffic_predictor`

## Requirements
- R1: After reset, `pred_vld_o` is 0, `pred_lvl_o` and `pred_src_o` are 0, and all four score totals are 0. Whenever `pred_vld_o` is 0, `pred_lvl_o` is 0.
- R2: Bytes of flits sent to a destination are summed over a period, saturating at the counter maximum. At a tick the sum maps to a level: below 16 gives 0, below 64 gives 1, below 192 gives 2, and 192 or more gives 3. A flit presented in the same cycle as the tick counts toward the new period.
- R3: A tick accepted at clock edge T starts a sweep. Destination d is processed at edge T+1+d, and its forecast reflects the new level from that edge on. With the chooser on the repeat side, the presented level equals the level just measured.
- R4: Each destination keeps its last four levels, the newest in bits [1:0]. After four completed periods, the period's level is written into the shared table under the key {destination, history before the shift}. The pattern forecast is valid only when the history is full and the key {destination, new history} is present. A write in the same step is visible to that lookup.
- R5: The shared table holds 8 entries. A write to a present key updates it in place. Otherwise it fills a free entry, or replaces the entry written least recently.
- R6: The chooser per destination is a 2-bit saturating counter that starts at 1. When the pattern forecast was valid and exactly one forecast hit, it steps up if the pattern forecast hit and down if the repeat forecast hit. The pattern forecast is presented when the counter is 2 or more and the pattern forecast is valid; otherwise the repeat forecast is presented.
- R7: In each sweep step of a destination already seen, the repeat hit or miss total increments (hit when forecast equals the measured level). When the pattern forecast was valid, the pattern hit or miss total increments too. Totals saturate.
- R8: `pred_src_o` is 1 exactly when the presented level for the queried destination comes from the pattern table.
- R9: A step whose old history and measured level are all zero writes nothing into the table, so idle destinations take no table entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_vld_i | input | 1 | A flit is sent this cycle |
| flit_dst_i | input | DST_W | Destination of the flit |
| flit_bytes_i | input | BYTE_W | Payload bytes of the flit |
| tick_i | input | 1 | Sampling period boundary; ignored while a sweep runs |
| query_dst_i | input | DST_W | Destination whose forecast is read |
| pred_vld_o | output | 1 | Queried destination has completed at least one period |
| pred_lvl_o | output | 2 | Forecast level for the queried destination |
| pred_src_o | output | 1 | Forecast comes from the pattern table |
| lvp_hit_o | output | SCORE_W | Repeat forecast hit total |
| lvp_miss_o | output | SCORE_W | Repeat forecast miss total |
| pop_hit_o | output | SCORE_W | Pattern forecast hit total |
| pop_miss_o | output | SCORE_W | Pattern forecast miss total |

## Verification
A corrupted history, table entry or LRU rank does not show up at once. It surfaces only when that destination's history recurs, typically one to four periods later. It then appears as a wrong `pred_lvl_o` or `pred_src_o` and a diverging pattern score total. A wrong chooser value or a mistimed sweep step shows on the query port in the very cycle after the step. The bench therefore tracks every destination, every table entry and every score every cycle, while the query rotates over all destinations. Repeating patterns are chosen so that the shared table is first under-subscribed and then thrashed.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/nvp_period_counter.sv
module nvp_period_counter
  import nvp_pkg::*;
#(
  parameter int NUM_DST = 16,
  parameter int DST_W   = 4,
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int TH1     = 16,
  parameter int TH2     = 64,
  parameter int TH3     = 192
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            flit_vld_i,
  input  logic [DST_W-1:0]                flit_dst_i,
  input  logic [BYTE_W-1:0]               flit_bytes_i,
  input  logic                            take_i,
  output logic [NUM_DST-1:0][LVL_W-1:0]   snap_o
);
  logic [CNT_W-1:0] bytes_ext;
  assign bytes_ext = CNT_W'(flit_bytes_i);

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic             hit;
    lvl_t             lvl;

    assign hit = flit_vld_i && (flit_dst_i == DST_W'(d));
    assign sum = {1'b0, cnt_q} + {1'b0, bytes_ext};

    always_comb begin
      if (cnt_q < CNT_W'(TH1))      lvl = 2'd0;
      else if (cnt_q < CNT_W'(TH2)) lvl = 2'd1;
      else if (cnt_q < CNT_W'(TH3)) lvl = 2'd2;
      else                          lvl = 2'd3;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q     <= '0;
        snap_o[d] <= '0;
      end else if (take_i) begin
        cnt_q     <= hit ? bytes_ext : '0;
        snap_o[d] <= lvl;
      end else if (hit) begin
        cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nvp_pattern_table.sv
module nvp_pattern_table
  import nvp_pkg::*;
#(
  parameter int KEY_W = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  lvl_t             wr_val_i,
  input  logic [KEY_W-1:0] rd_key_i,
  output logic             rd_hit_o,
  output lvl_t             rd_val_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [KEY_W-1:0] key_q  [DEPTH];
  lvl_t             val_q  [DEPTH];
  logic [IDX_W-1:0] rank_q [DEPTH];

  logic             hit_found, free_found;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, wr_idx;

  always_comb begin
    hit_found  = 1'b0;
    free_found = 1'b0;
    hit_idx    = '0;
    free_idx   = '0;
    lru_idx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit_found && vld_q[i] && key_q[i] == wr_key_i) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
      if (!free_found && !vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (rank_q[i] == IDX_W'(DEPTH-1)) lru_idx = IDX_W'(i);
    end
    wr_idx = hit_found ? hit_idx : (free_found ? free_idx : lru_idx);
  end

  // lookup sees the table as it stands after this cycle's write
  always_comb begin
    rd_hit_o = 1'b0;
    rd_val_o = '0;
    if (wr_en_i && rd_key_i == wr_key_i) begin
      rd_hit_o = 1'b1;
      rd_val_o = wr_val_i;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld_q[i] && key_q[i] == rd_key_i && !(wr_en_i && wr_idx == IDX_W'(i))) begin
          rd_hit_o = 1'b1;
          rd_val_o = val_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i]  <= '0;
        val_q[i]  <= '0;
        rank_q[i] <= IDX_W'(i);
      end
    end else if (wr_en_i) begin
      vld_q[wr_idx] <= 1'b1;
      key_q[wr_idx] <= wr_key_i;
      val_q[wr_idx] <= wr_val_i;
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_idx == IDX_W'(i))             rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[wr_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvp_sat_counter.sv
module nvp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (inc_i && ~&cnt_o)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nvp_traffic_predictor.sv
module nvp_traffic_predictor
  import nvp_pkg::*;
#(
  parameter int NUM_DST   = 16,
  parameter int DST_W     = $clog2(NUM_DST),
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 16,
  parameter int HIST_LEN  = 4,
  parameter int TBL_DEPTH = 8,
  parameter int SCORE_W   = 16,
  parameter int TH1       = 16,
  parameter int TH2       = 64,
  parameter int TH3       = 192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flit_vld_i,
  input  logic [DST_W-1:0]   flit_dst_i,
  input  logic [BYTE_W-1:0]  flit_bytes_i,
  input  logic               tick_i,
  input  logic [DST_W-1:0]   query_dst_i,
  output logic               pred_vld_o,
  output logic [1:0]         pred_lvl_o,
  output logic               pred_src_o,
  output logic [SCORE_W-1:0] lvp_hit_o,
  output logic [SCORE_W-1:0] lvp_miss_o,
  output logic [SCORE_W-1:0] pop_hit_o,
  output logic [SCORE_W-1:0] pop_miss_o
);
  localparam int HIST_W = LVL_W * HIST_LEN;
  localparam int KEY_W  = DST_W + HIST_W;
  localparam int HC_W   = $clog2(HIST_LEN + 1);

  logic                          busy_q, take;
  logic [DST_W-1:0]              ptr_q;
  logic [NUM_DST-1:0][LVL_W-1:0] snap;

  lvl_t              last_q [NUM_DST];
  lvl_t              pp_q   [NUM_DST];
  logic [HIST_W-1:0] hist_q [NUM_DST];
  logic [HC_W-1:0]   hcnt_q [NUM_DST];
  logic [1:0]        sel_q  [NUM_DST];
  logic [NUM_DST-1:0] seen_q, pv_q;

  assign take = tick_i & ~busy_q;

  nvp_period_counter #(
    .NUM_DST(NUM_DST), .DST_W(DST_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .TH1(TH1), .TH2(TH2), .TH3(TH3)
  ) u_cnt (
    .clk_i, .rst_ni, .flit_vld_i, .flit_dst_i, .flit_bytes_i,
    .take_i(take), .snap_o(snap)
  );

  // current sweep step
  lvl_t              act, rd_val;
  logic              hist_full, nxt_full, idle_flow, wr_en, rd_hit;
  logic              lvp_eq, pop_eq, cur_seen, cur_pv;
  logic [HIST_W-1:0] new_hist;

  assign act       = snap[ptr_q];
  assign cur_seen  = seen_q[ptr_q];
  assign cur_pv    = pv_q[ptr_q];
  assign hist_full = hcnt_q[ptr_q] == HC_W'(HIST_LEN);
  assign nxt_full  = hist_full | (hcnt_q[ptr_q] == HC_W'(HIST_LEN-1));
  assign idle_flow = (hist_q[ptr_q] == '0) && (act == '0);
  assign new_hist  = {hist_q[ptr_q][HIST_W-LVL_W-1:0], act};
  assign lvp_eq    = last_q[ptr_q] == act;
  assign pop_eq    = pp_q[ptr_q] == act;
  assign wr_en     = busy_q & hist_full & ~idle_flow;

  nvp_pattern_table #(.KEY_W(KEY_W), .DEPTH(TBL_DEPTH)) u_tbl (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en),
    .wr_key_i({ptr_q, hist_q[ptr_q]}),
    .wr_val_i(act),
    .rd_key_i({ptr_q, new_hist}),
    .rd_hit_o(rd_hit),
    .rd_val_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == DST_W'(NUM_DST-1)) busy_q <= 1'b0;
    end else if (take) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      pv_q   <= '0;
      for (int d = 0; d < NUM_DST; d++) begin
        last_q[d] <= '0;
        pp_q[d]   <= '0;
        hist_q[d] <= '0;
        hcnt_q[d] <= '0;
        sel_q[d]  <= 2'd1;
      end
    end else if (busy_q) begin
      if (cur_pv && (lvp_eq != pop_eq)) begin
        if (pop_eq && sel_q[ptr_q] != 2'd3)       sel_q[ptr_q] <= sel_q[ptr_q] + 2'd1;
        else if (!pop_eq && sel_q[ptr_q] != 2'd0) sel_q[ptr_q] <= sel_q[ptr_q] - 2'd1;
      end
      hist_q[ptr_q] <= new_hist;
      if (!hist_full) hcnt_q[ptr_q] <= hcnt_q[ptr_q] + 1'b1;
      last_q[ptr_q] <= act;
      seen_q[ptr_q] <= 1'b1;
      pv_q[ptr_q]   <= nxt_full & rd_hit;
      pp_q[ptr_q]   <= rd_val;
    end
  end

  nvp_sat_counter #(.W(SCORE_W)) u_lvp_hit (
    .clk_i, .rst_ni, .inc_i(busy_q & cur_seen & lvp_eq),  .cnt_o(lvp_hit_o));
  nvp_sat_counter #(.W(SCORE_W)) u_lvp_miss (
    .clk_i, .rst_ni, .inc_i(busy_q & cur_seen & ~lvp_eq), .cnt_o(lvp_miss_o));
  nvp_sat_counter #(.W(SCORE_W)) u_pop_hit (
    .clk_i, .rst_ni, .inc_i(busy_q & cur_pv & pop_eq),    .cnt_o(pop_hit_o));
  nvp_sat_counter #(.W(SCORE_W)) u_pop_miss (
    .clk_i, .rst_ni, .inc_i(busy_q & cur_pv & ~pop_eq),   .cnt_o(pop_miss_o));

  logic use_pop;
  assign use_pop    = sel_q[query_dst_i][1] & pv_q[query_dst_i];
  assign pred_vld_o = seen_q[query_dst_i];
  assign pred_src_o = use_pop;
  assign pred_lvl_o = use_pop ? pp_q[query_dst_i] : last_q[query_dst_i];
endmodule

// File: rtl/nvp_traffic_predictor_chk.sv
module nvp_traffic_predictor_chk #(
  parameter int SCORE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pred_vld_o,
  input logic [1:0]         pred_lvl_o,
  input logic               pred_src_o,
  input logic [SCORE_W-1:0] lvp_hit_o,
  input logic [SCORE_W-1:0] lvp_miss_o,
  input logic [SCORE_W-1:0] pop_hit_o,
  input logic [SCORE_W-1:0] pop_miss_o
);
  logic [SCORE_W:0] lvp_tot, pop_tot;
  assign lvp_tot = {1'b0, lvp_hit_o} + {1'b0, lvp_miss_o};
  assign pop_tot = {1'b0, pop_hit_o} + {1'b0, pop_miss_o};

  // R1
  idle_lvl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_vld_o |-> pred_lvl_o == 2'd0);

  // R8
  src_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_src_o |-> pred_vld_o);

  // R7
  lvp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvp_tot >= $past(lvp_tot)) && (lvp_tot <= $past(lvp_tot) + {{SCORE_W{1'b0}}, 1'b1}));

  // R7
  pop_with_lvp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_tot != $past(pop_tot)) |-> (lvp_tot != $past(lvp_tot)));

  // R7
  pop_hit_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_hit_o >= $past(pop_hit_o));
endmodule

bind nvp_traffic_predictor nvp_traffic_predictor_chk #(.SCORE_W(SCORE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pred_vld_o(pred_vld_o), .pred_lvl_o(pred_lvl_o),
  .pred_src_o(pred_src_o), .lvp_hit_o(lvp_hit_o), .lvp_miss_o(lvp_miss_o),
  .pop_hit_o(pop_hit_o), .pop_miss_o(pop_miss_o)
);

// File: tb/nvp_traffic_predictor_bench.sv
`timescale 1ns/1ps
module nvp_traffic_predictor_bench;
  localparam int ND = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flit_vld_i = 1'b0;
  logic [3:0] flit_dst_i = '0;
  logic [7:0] flit_bytes_i = '0;
  logic       tick_i = 1'b0;
  logic [3:0] query_dst_i = '0;
  logic       pred_vld_o, pred_src_o;
  logic [1:0] pred_lvl_o;
  logic [15:0] lvp_hit_o, lvp_miss_o, pop_hit_o, pop_miss_o;

  always #5 clk_i = ~clk_i;

  nvp_traffic_predictor u_nvp_traffic_predictor (
    .clk_i, .rst_ni, .flit_vld_i, .flit_dst_i, .flit_bytes_i, .tick_i, .query_dst_i,
    .pred_vld_o, .pred_lvl_o, .pred_src_o,
    .lvp_hit_o, .lvp_miss_o, .pop_hit_o, .pop_miss_o
  );

  int tests = 0, fails = 0, cyc = 0;
  bit live_cmp = 1'b0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt[ND], m_snap[ND], m_last[ND], m_hist[ND], m_hn[ND], m_sel[ND], m_pp[ND];
  bit m_seen[ND], m_pv[ND];
  bit m_busy;
  int m_ptr, m_lh, m_lm, m_ph, m_pm;
  int t_key[$];
  int t_val[$];

  function automatic int quant(int c);
    if (c < 16) return 0;
    if (c < 64) return 1;
    if (c < 192) return 2;
    return 3;
  endfunction

  function automatic int inc_sat(int v);
    return (v < 65535) ? v + 1 : v;
  endfunction

  function automatic void tbl_write(int key, int val);
    for (int i = 0; i < t_key.size(); i++) begin
      if (t_key[i] == key) begin
        t_key.delete(i);
        t_val.delete(i);
        break;
      end
    end
    if (t_key.size() == 8) begin
      void'(t_key.pop_back());
      void'(t_val.pop_back());
    end
    t_key.push_front(key);
    t_val.push_front(val);
  endfunction

  function automatic void step(int d);
    int a;
    bit lh, ph;
    a = m_snap[d];
    lh = (m_last[d] == a);
    ph = (m_pp[d] == a);
    if (m_seen[d]) begin
      if (lh) m_lh = inc_sat(m_lh); else m_lm = inc_sat(m_lm);
    end
    if (m_pv[d]) begin
      if (ph) m_ph = inc_sat(m_ph); else m_pm = inc_sat(m_pm);
      if (lh != ph) begin
        if (ph && m_sel[d] < 3) m_sel[d]++;
        else if (!ph && m_sel[d] > 0) m_sel[d]--;
      end
    end
    if (m_hn[d] == 4 && !(m_hist[d] == 0 && a == 0)) tbl_write(d * 256 + m_hist[d], a);
    m_hist[d] = (m_hist[d] * 4 + a) & 255;
    if (m_hn[d] < 4) m_hn[d]++;
    m_last[d] = a;
    m_seen[d] = 1'b1;
    m_pv[d] = 1'b0;
    m_pp[d] = 0;
    if (m_hn[d] == 4) begin
      for (int i = 0; i < t_key.size(); i++) begin
        if (t_key[i] == d * 256 + m_hist[d]) begin
          m_pv[d] = 1'b1;
          m_pp[d] = t_val[i];
        end
      end
    end
  endfunction

  always @(posedge clk_i) begin
    bit was_busy;
    if (!rst_ni) begin
      for (int d = 0; d < ND; d++) begin
        m_cnt[d] = 0; m_snap[d] = 0; m_last[d] = 0; m_hist[d] = 0; m_hn[d] = 0;
        m_sel[d] = 1; m_pp[d] = 0; m_seen[d] = 0; m_pv[d] = 0;
      end
      m_busy = 0; m_ptr = 0; m_lh = 0; m_lm = 0; m_ph = 0; m_pm = 0;
      t_key.delete();
      t_val.delete();
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        step(m_ptr);
        if (m_ptr == ND - 1) m_busy = 0;
        m_ptr++;
      end
      if (tick_i && !was_busy) begin
        for (int d = 0; d < ND; d++) begin
          m_snap[d] = quant(m_cnt[d]);
          m_cnt[d] = 0;
        end
        m_busy = 1;
        m_ptr = 0;
      end
      if (flit_vld_i) begin
        m_cnt[flit_dst_i] += flit_bytes_i;
        if (m_cnt[flit_dst_i] > 65535) m_cnt[flit_dst_i] = 65535;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && live_cmp) begin
      int q;
      bit up;
      q = query_dst_i;
      up = m_sel[q] >= 2 && m_pv[q];
      chk("R3 valid", pred_vld_o, m_seen[q]);
      chk("R3 R4 R5 R6 R9 level", pred_lvl_o, up ? m_pp[q] : m_last[q]);
      chk("R8 source", pred_src_o, up);
      chk("R7 lvp hits", lvp_hit_o, m_lh);
      chk("R7 lvp misses", lvp_miss_o, m_lm);
      chk("R7 pop hits", pop_hit_o, m_ph);
      chk("R7 pop misses", pop_miss_o, m_pm);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  int plan[ND];

  task automatic drive(bit v, int dst, int bytes, bit tk);
    @(posedge clk_i);
    #2;
    flit_vld_i   = v;
    flit_dst_i   = 4'(dst);
    flit_bytes_i = 8'(bytes);
    tick_i       = tk;
    query_dst_i  = 4'(cyc % ND);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  function automatic int lvl_bytes(int l);
    case (l)
      1: return 30;
      2: return 100;
      3: return 250;
      default: return 0;
    endcase
  endfunction

  task automatic run_period();
    for (int d = 0; d < ND; d++)
      if (plan[d] > 0) drive(1, d, lvl_bytes(plan[d]), 0);
    drive(0, 0, 0, 1);
    idle(20);
  endtask

  task automatic query_chk(int d, int exp, string req);
    @(posedge clk_i);
    #2;
    query_dst_i = 4'(d);
    @(negedge clk_i);
    chk(req, pred_lvl_o, exp);
  endtask

  initial begin
    int seq_a[4] = '{1, 2, 3, 0};
    int seq_b[3] = '{3, 3, 1};
    int seq_c[2] = '{2, 1};
    int seq_d[4] = '{3, 0, 2, 1};
    repeat (4) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 vld", pred_vld_o, 0);
    chk("R1 lvl", pred_lvl_o, 0);
    chk("R1 src", pred_src_o, 0);
    chk("R1 scores", lvp_hit_o + lvp_miss_o + pop_hit_o + pop_miss_o, 0);
    live_cmp = 1'b1;

    // R2 threshold boundaries, flit on tick cycle goes to next period
    drive(1, 0, 15, 0);
    drive(1, 1, 16, 0);
    drive(1, 2, 63, 0);
    drive(1, 3, 64, 0);
    drive(1, 4, 191, 0);
    drive(1, 5, 192, 0);
    drive(1, 6, 100, 0);
    drive(1, 6, 100, 0);
    drive(1, 7, 250, 1);
    drive(0, 0, 0, 0);
    idle(20);
    query_chk(0, 0, "R2 15B");
    query_chk(1, 1, "R2 16B");
    query_chk(2, 1, "R2 63B");
    query_chk(3, 2, "R2 64B");
    query_chk(4, 2, "R2 191B");
    query_chk(5, 3, "R2 192B");
    query_chk(6, 3, "R2 two flits");
    query_chk(7, 0, "R2 tick-cycle flit");
    for (int d = 0; d < ND; d++) plan[d] = 0;
    run_period();
    query_chk(7, 3, "R2 carried flit");
    query_chk(5, 0, "R3 last value");

    // repeating patterns, working set fits the table
    for (int p = 0; p < 20; p++) begin
      plan[3] = seq_a[p % 4];
      plan[9] = seq_b[p % 3];
      run_period();
    end
    @(negedge clk_i);
    chk("R4 pattern hits seen", int'(pop_hit_o > 0), 1);
    chk("R7 lvp misses seen", int'(lvp_miss_o > 0), 1);
    @(posedge clk_i);
    #2 query_dst_i = 4'd3;
    @(negedge clk_i);
    chk("R6 chooser on pattern", pred_src_o, 1);

    // working set exceeds the table: LRU eviction
    for (int p = 0; p < 12; p++) begin
      plan[3]  = seq_a[p % 4];
      plan[9]  = seq_b[p % 3];
      plan[10] = seq_c[p % 2];
      plan[11] = seq_d[p % 4];
      run_period();
    end
    idle(4);
    live_cmp = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule